// File: doc/BRIEF.md
# Repeating-Mode FM Envelope Generator

This block is the envelope generator for one operator of an FM voice. It steps an attenuation value through attack, decay, sustain and release states. A 4-bit mode field adds a repeating envelope on top of these states. Bit 3 enables the mode. Bit 2 inverts the output from the attack onward. Bit 1 selects alternation, which flips the inversion on each repeat. Bit 0 selects hold, which freezes the envelope after the first pass instead of looping.

The rate tables live outside the block. A `step` input tells the block when the current state may advance by one step. Key events arrive as single-cycle `key_on` and `key_off` strobes. A level input `csm_key` blocks both kinds of key event. The attenuation output is registered and already includes the total level. A one-cycle `phase_rst` pulse tells the operator's phase generator to restart.

Top module: `eg_ssg_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `env_out` is 0x3FF and `phase_rst` is 0. The internal state is idle, the attenuation is 0x3FF, and the key flag and the inversion flag are both clear.
- R2: A `key_on` strobe takes effect only when the key flag is clear and `csm_key` is low. It sets the key flag, clears the inversion flag and enters the attack state, and `phase_rst` is high for exactly the next cycle. A `key_on` while the key flag is set is ignored.
- R3: A `key_off` strobe takes effect only when the key flag is set and `csm_key` is low. It clears the key flag. If the state is attack, decay or sustain, the block enters release. From release or idle, only the key flag changes.
- R4: While `csm_key` is high, neither key strobe changes the key flag, the state or the attenuation.
- R5: On an effective `key_off` from attack, decay or sustain with `ssg_mode[3]` set, the attenuation is rewritten if the inversion flag XOR `ssg_mode[2]` is 1. The new value is (attenuation XOR 0x1FF) + 1.
- R6: After the R5 step, an attenuation of 0x200 or more is forced to 0x3FF and the state becomes idle.
- R7: `env_out` is registered. Let `s` be the attenuation, except when `ssg_mode[3]` is set, the inversion flag XOR `ssg_mode[2]` is 1 and the state is attack, decay or sustain; then `s` is (0x200 − attenuation) mod 0x400. One cycle after that state, `env_out` equals `s` + 8·`total_level`.
- R8: A repeat event fires in any cycle where `ssg_mode[3]` is set, the attenuation is at least 0x200 and the state is attack, decay or sustain. This check does not depend on `step`. A repeat event never fires in release or idle.
- R9: On a repeat event in hold mode (`ssg_mode[0]`=1), `ssg_mode[1]` sets the inversion flag. The attenuation becomes 0 if the inversion flag XOR `ssg_mode[2]` is then 1, and 0x3FF otherwise (written internally as 0x200 and 0x3FF). The state is kept and no `phase_rst` pulse is sent.
- R10: On a repeat event in loop mode (`ssg_mode[0]`=0), `ssg_mode[1]` toggles the inversion flag; otherwise `phase_rst` pulses. The state becomes attack. If `step` is high, one attack step is applied in the same cycle, so a repeat can fire on every cycle.
- R11: When `step` is high and no key event or repeat event takes effect, the state advances one step. In attack, the attenuation a becomes a − (a>>3) − 1, and at 0 the state moves to decay. In decay, the attenuation rises by 16, and once it reaches `sus_lvl` the state moves to sustain. Priority order is: key event, then repeat event, then step.
- R12: In sustain and release, the attenuation rises by 16 and saturates at 0x3FF. Release becomes idle once the attenuation is 0x3FF. The attenuation never falls during release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_on | input | 1 | Key-on strobe |
| key_off | input | 1 | Key-off strobe |
| csm_key | input | 1 | Blocks both key strobes while high |
| step | input | 1 | Rate-step enable for the current state |
| total_level | input | 7 | Total level, added as 8·value |
| sus_lvl | input | 10 | Decay-to-sustain threshold |
| ssg_mode | input | 4 | Mode field: [3] enable, [2] invert, [1] alternate, [0] hold |
| env_out | output | 11 | Registered attenuation output |
| phase_rst | output | 1 | One-cycle phase-generator restart pulse |

## Verification
`phase_rst`, the key flag and the state all change at the clock edge where the causing inputs are sampled. `env_out` is one more register behind: it shows the state as it stood before that edge, so a stimulus first reaches it two edges later.

The reference model follows the same timing. On each edge it first computes the expected `env_out` from its stored state and the current inputs, and only then updates that state. Both outputs are compared at the following falling edge.

// File: rtl/eg_ssg_pkg.sv
package eg_ssg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RELEASE = 3'd1,
    ST_SUSTAIN = 3'd2,
    ST_DECAY   = 3'd3,
    ST_ATTACK  = 3'd4
  } eg_state_e;
endpackage

// File: rtl/eg_advance.sv
module eg_advance
  import eg_ssg_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DSTEP = 16,
  parameter int ASH   = 3
) (
  input  eg_state_e         st,
  input  logic [AW-1:0]     att,
  input  logic [AW-1:0]     sus_lvl,
  output eg_state_e         st_nx,
  output logic [AW-1:0]     att_nx,
  output logic [AW-1:0]     att_dn
);
  localparam logic [AW-1:0] MAXV  = '1;
  localparam logic [AW-1:0] ONE   = AW'(1);
  localparam logic [AW:0]   STEPV = (AW+1)'(DSTEP);

  logic [AW:0]   inc_w;
  logic [AW-1:0] inc_sat;

  assign inc_w   = {1'b0, att} + STEPV;
  assign inc_sat = (inc_w > {1'b0, MAXV}) ? MAXV : inc_w[AW-1:0];
  assign att_dn  = att - (att >> ASH) - ONE;

  always_comb begin
    st_nx  = st;
    att_nx = att;
    case (st)
      ST_ATTACK: begin
        if (att == '0) st_nx = ST_DECAY;
        else           att_nx = att_dn;
      end
      ST_DECAY: begin
        if (att >= sus_lvl) st_nx = ST_SUSTAIN;
        else                att_nx = inc_sat;
      end
      ST_SUSTAIN: att_nx = inc_sat;
      ST_RELEASE: begin
        if (att == MAXV) st_nx = ST_IDLE;
        else             att_nx = inc_sat;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/eg_loop_ctrl.sv
module eg_loop_ctrl
  import eg_ssg_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [3:0]        mode,
  input  eg_state_e         st,
  input  logic [AW-1:0]     att,
  input  logic [AW-1:0]     att_dn,
  input  logic              inv,
  input  logic              step,
  output logic              fire,
  output eg_state_e         st_nx,
  output logic [AW-1:0]     att_nx,
  output logic              inv_nx,
  output logic              prst
);
  localparam logic [AW-1:0] MAXV = '1;
  localparam logic [AW-1:0] HALF = {1'b1, {(AW-1){1'b0}}};

  assign fire = mode[3] && (att >= HALF) && (st > ST_RELEASE);

  always_comb begin
    st_nx  = st;
    att_nx = att;
    inv_nx = inv;
    prst   = 1'b0;
    if (mode[0]) begin
      inv_nx = inv | mode[1];
      att_nx = (inv_nx ^ mode[2]) ? HALF : MAXV;
    end else begin
      if (mode[1]) inv_nx = ~inv;
      else         prst   = 1'b1;
      st_nx = ST_ATTACK;
      if (step) att_nx = att_dn;
    end
  end
endmodule

// File: rtl/eg_shaper.sv
module eg_shaper
  import eg_ssg_pkg::*;
#(
  parameter int AW  = 10,
  parameter int TLW = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        mode,
  input  eg_state_e         st,
  input  logic [AW-1:0]     att,
  input  logic              inv,
  input  logic [TLW-1:0]    tl,
  output logic [AW:0]       env
);
  localparam int            OW   = AW + 1;
  localparam logic [AW-1:0] MAXV = '1;
  localparam logic [AW-1:0] HALF = {1'b1, {(AW-1){1'b0}}};

  logic          flip;
  logic [AW-1:0] shaped;

  assign flip   = mode[3] && (inv ^ mode[2]) && (st > ST_RELEASE);
  assign shaped = flip ? (HALF - att) : att;

  always_ff @(posedge clk) begin
    if (rst) env <= {1'b0, MAXV};
    else     env <= {1'b0, shaped} + (OW'(tl) << 3);
  end
endmodule

// File: rtl/eg_ssg_top.sv
module eg_ssg_top
  import eg_ssg_pkg::*;
#(
  parameter int AW    = 10,
  parameter int TLW   = 7,
  parameter int DSTEP = 16,
  parameter int ASH   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            key_on,
  input  logic            key_off,
  input  logic            csm_key,
  input  logic            step,
  input  logic [TLW-1:0]  total_level,
  input  logic [AW-1:0]   sus_lvl,
  input  logic [3:0]      ssg_mode,
  output logic [AW:0]     env_out,
  output logic            phase_rst
);
  localparam logic [AW-1:0] MAXV  = '1;
  localparam logic [AW-1:0] HALF  = {1'b1, {(AW-1){1'b0}}};
  localparam logic [AW:0]   LOWM  = {2'b00, {(AW-1){1'b1}}};
  localparam logic [AW:0]   ONEW  = (AW+1)'(1);

  eg_state_e     state_q;
  logic [AW-1:0] att_q;
  logic          key_q;
  logic          inv_q;
  logic          prst_q;

  eg_state_e     adv_st;
  logic [AW-1:0] adv_att;
  logic [AW-1:0] att_dn;

  logic          fire;
  eg_state_e     lp_st;
  logic [AW-1:0] lp_att;
  logic          lp_inv;
  logic          lp_prst;

  logic          kon_ok;
  logic          koff_ok;
  logic [AW:0]   ko_v;
  logic          ko_off;

  eg_advance #(.AW(AW), .DSTEP(DSTEP), .ASH(ASH)) u_adv (
    .st(state_q), .att(att_q), .sus_lvl(sus_lvl),
    .st_nx(adv_st), .att_nx(adv_att), .att_dn(att_dn)
  );

  eg_loop_ctrl #(.AW(AW)) u_loop (
    .mode(ssg_mode), .st(state_q), .att(att_q), .att_dn(att_dn),
    .inv(inv_q), .step(step), .fire(fire), .st_nx(lp_st),
    .att_nx(lp_att), .inv_nx(lp_inv), .prst(lp_prst)
  );

  eg_shaper #(.AW(AW), .TLW(TLW)) u_shape (
    .clk(clk), .rst(rst), .mode(ssg_mode), .st(state_q),
    .att(att_q), .inv(inv_q), .tl(total_level), .env(env_out)
  );

  assign kon_ok  = key_on  && !key_q && !csm_key;
  assign koff_ok = key_off &&  key_q && !csm_key;
  assign ko_v    = (inv_q ^ ssg_mode[2]) ? (({1'b0, att_q} ^ LOWM) + ONEW)
                                         : {1'b0, att_q};
  assign ko_off  = ko_v >= {1'b0, HALF};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      att_q   <= MAXV;
      key_q   <= 1'b0;
      inv_q   <= 1'b0;
      prst_q  <= 1'b0;
    end else begin
      prst_q <= 1'b0;
      if (kon_ok) begin
        key_q   <= 1'b1;
        inv_q   <= 1'b0;
        state_q <= ST_ATTACK;
        prst_q  <= 1'b1;
      end else if (koff_ok) begin
        key_q <= 1'b0;
        if (state_q > ST_RELEASE) begin
          state_q <= ST_RELEASE;
          if (ssg_mode[3]) begin
            if (ko_off) begin
              att_q   <= MAXV;
              state_q <= ST_IDLE;
            end else begin
              att_q <= ko_v[AW-1:0];
            end
          end
        end
      end else if (fire) begin
        state_q <= lp_st;
        att_q   <= lp_att;
        inv_q   <= lp_inv;
        prst_q  <= lp_prst;
      end else if (step) begin
        state_q <= adv_st;
        att_q   <= adv_att;
      end
    end
  end

  assign phase_rst = prst_q;

  // R2
  keyon_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (key_on && !key_q && !csm_key) |=> (phase_rst && key_q && state_q == ST_ATTACK));

  // R4
  csm_block_chk: assert property (@(posedge clk) disable iff (rst)
    csm_key |=> $stable(key_q));

  // R3
  keyoff_rel_chk: assert property (@(posedge clk) disable iff (rst)
    (key_off && key_q && !csm_key && state_q > ST_RELEASE) |=> (state_q <= ST_RELEASE && !key_q));

  // R6
  keyoff_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (key_off && key_q && !csm_key && state_q > ST_RELEASE && ssg_mode[3] &&
     att_q >= HALF && !(inv_q ^ ssg_mode[2])) |=> (state_q == ST_IDLE && att_q == MAXV));

  // R9
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && ssg_mode[0] && !kon_ok && !koff_ok) |=> ($stable(state_q) && !phase_rst));

  // R12
  rel_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RELEASE && !kon_ok) |=> (att_q >= $past(att_q)));

  // R8
  no_repeat_rel_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q <= ST_RELEASE) |-> !fire);
endmodule

// File: tb/sim_eg_ssg_top.sv
`timescale 1ns/1ps
module sim_eg_ssg_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        key_on = 1'b0, key_off = 1'b0, csm_key = 1'b0, step = 1'b0;
  logic [6:0]  total_level = '0;
  logic [9:0]  sus_lvl = 10'd256;
  logic [3:0]  ssg_mode = 4'd0;
  logic [10:0] env_out;
  logic        phase_rst;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  int m_st, m_att, m_key, m_inv, e_env, e_prst;

  always #10 clk = ~clk;

  eg_ssg_top u0 (
    .clk(clk), .rst(rst), .key_on(key_on), .key_off(key_off),
    .csm_key(csm_key), .step(step), .total_level(total_level),
    .sus_lvl(sus_lvl), .ssg_mode(ssg_mode), .env_out(env_out),
    .phase_rst(phase_rst)
  );

  function automatic int shape_exp(int st, int att, int inv, logic [3:0] md, int tl);
    int s;
    s = att;
    if (md[3] && ((inv ^ int'(md[2])) != 0) && st > 1) s = (512 - att) & 1023;
    return s + tl * 8;
  endfunction

  function automatic int rise(int a);
    return (a + 16 > 1023) ? 1023 : a + 16;
  endfunction

  task automatic model_edge();
    int eff, v;
    e_env  = shape_exp(m_st, m_att, m_inv, ssg_mode, int'(total_level));
    e_prst = 0;
    eff    = m_inv ^ int'(ssg_mode[2]);
    if (key_on && m_key == 0 && !csm_key) begin
      m_key = 1; m_inv = 0; m_st = 4; e_prst = 1;
    end else if (key_off && m_key == 1 && !csm_key) begin
      m_key = 0;
      if (m_st > 1) begin
        m_st = 1;
        if (ssg_mode[3]) begin
          v = (eff != 0) ? ((m_att ^ 511) + 1) : m_att;
          if (v >= 512) begin v = 1023; m_st = 0; end
          m_att = v;
        end
      end
    end else if (ssg_mode[3] && m_att >= 512 && m_st > 1) begin
      if (ssg_mode[0]) begin
        if (ssg_mode[1]) m_inv = 1;
        m_att = ((m_inv ^ int'(ssg_mode[2])) != 0) ? 512 : 1023;
      end else begin
        if (ssg_mode[1]) m_inv = 1 - m_inv;
        else e_prst = 1;
        m_st = 4;
        if (step) m_att = m_att - m_att / 8 - 1;
      end
    end else if (step) begin
      case (m_st)
        4: if (m_att == 0) m_st = 3; else m_att = m_att - m_att / 8 - 1;
        3: if (m_att >= int'(sus_lvl)) m_st = 2; else m_att = rise(m_att);
        2: m_att = rise(m_att);
        1: if (m_att == 1023) m_st = 0; else m_att = rise(m_att);
        default: ;
      endcase
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    n_chk++;
    if (int'(env_out) != e_env) begin
      n_fail++;
      $display("FAIL %s env_out act=%0d exp=%0d", tag, env_out, e_env);
    end
    n_chk++;
    if (int'(phase_rst) != e_prst) begin
      n_fail++;
      $display("FAIL %s phase_rst act=%0d exp=%0d", tag, phase_rst, e_prst);
    end
  endtask

  task automatic run_case(input logic [3:0] md, input int tl, input int sl,
                          input int on_n, input int per, input int off_n, input string t);
    tag = t;
    ssg_mode = md; total_level = 7'(tl); sus_lvl = 10'(sl);
    key_on = 1'b1; tick(); key_on = 1'b0;
    for (int i = 0; i < on_n; i++) begin
      step   = (i % per == 0);
      key_on = (i == 5);
      tick();
    end
    key_on = 1'b0; step = 1'b1; key_off = 1'b1; tick(); key_off = 1'b0;
    for (int i = 0; i < off_n; i++) begin
      step    = (i % per == 0);
      key_off = (i == 3);
      tick();
    end
    key_off = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (env_out != 11'h3FF || phase_rst !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset act=%0d/%0d exp=1023/0", env_out, phase_rst);
    end
    m_st = 0; m_att = 1023; m_key = 0; m_inv = 0;
    rst = 1'b0;
    tag = "R1"; tick();

    run_case(4'b0000, 0, 256, 200, 1, 120, "R11");
    run_case(4'b0000, 20, 600, 60, 1, 80, "R12");
    run_case(4'b0000, 0, 256, 30, 2, 60, "R2");
    run_case(4'b1000, 0, 900, 250, 1, 40, "R10");
    run_case(4'b1010, 0, 900, 250, 1, 40, "R10");
    run_case(4'b1100, 5, 900, 250, 3, 40, "R10");
    run_case(4'b1110, 0, 1023, 250, 1, 40, "R7");
    run_case(4'b1001, 0, 900, 150, 1, 40, "R9");
    run_case(4'b1011, 0, 900, 150, 1, 40, "R9");
    run_case(4'b1101, 0, 900, 150, 1, 40, "R9");
    run_case(4'b1111, 127, 900, 150, 1, 40, "R9");
    run_case(4'b1000, 0, 900, 200, 4, 60, "R8");
    run_case(4'b1010, 0, 900, 47, 1, 80, "R5");
    run_case(4'b1100, 0, 900, 30, 1, 80, "R5");
    run_case(4'b1010, 0, 900, 75, 1, 80, "R6");
    run_case(4'b1000, 50, 900, 90, 1, 80, "R6");
    run_case(4'b0000, 0, 256, 10, 1, 60, "R3");

    tag = "R4";
    ssg_mode = 4'b1000; csm_key = 1'b1; key_on = 1'b1; step = 1'b1;
    tick(); tick();
    key_on = 1'b0; csm_key = 1'b0;
    key_on = 1'b1; tick(); key_on = 1'b0;
    for (int i = 0; i < 20; i++) tick();
    csm_key = 1'b1; key_off = 1'b1; tick(); tick();
    key_off = 1'b0; csm_key = 1'b0;
    for (int i = 0; i < 20; i++) tick();
    key_off = 1'b1; tick(); key_off = 1'b0;
    for (int i = 0; i < 20; i++) tick();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule